// File: doc/BRIEF.md
# Power-Up Initialization Sequencer

This block brings a time-slot switch device out of power-up in a fixed order. While it runs, it keeps the device's output-enable line low, so the serial outputs stay tristated and the high-impedance indicators stay high. It also keeps the test-access reset line low, so the boundary-scan controller stays disabled. It pulses the device reset low, then waits a settling time that depends on the input clock rate. It then writes the clock-frequency field of the device control register over a simple write-request port and waits again. Next it programs every connection-memory entry in one continuous pass. Only after that does it release output enable.

A host pulses `start_i`. The oscillator option and the two-bit clock-rate code are captured in that same cycle. Every delay is counted in cycles of the sequencer's own clock. The parameters set each delay so that it meets the required minimum time at the clock rate in use. With the default values at 50 MHz:

- the reset pulse is 64 cycles, which is longer than 1 µs;
- one settle unit is 25,000 cycles, which is 500 µs.

The settling wait is one settle unit with an external oscillator or a 16.384 MHz input clock, two units for 8.192 MHz and four units for 4.096 MHz.

Top module: `pwrup_init_seq`

## Requirements
- R1: While `rst_ni` is low and while idle after reset, the outputs are `dev_rst_no`=1, `trst_no`=0, `ode_o`=0, `wr_req_o`=0 and `done_o`=0. An `wr_ack_i` pulse with no request pending has no effect on them.
- R2: From the start of a sequence until its last connection-memory write is acknowledged, `ode_o` and `trst_no` stay low.
- R3: A `start_i` sampled high while idle or done drives `dev_rst_no` low from the next cycle, for exactly RST_PULSE_CYC cycles. A `start_i` sampled while a sequence runs is ignored.
- R4: After `dev_rst_no` returns high, `wr_req_o` stays low for exactly SETTLE_UNIT_CYC×k cycles and then rises. k is 1 when `osc_ext_i` was high at start. Otherwise k comes from the captured `clk_code_i`: 2'b00 (4.096 MHz) gives k=4, 2'b01 (8.192 MHz) gives k=2, and 2'b10 (16.384 MHz) or 2'b11 give k=1.
- R5: The first write request goes to address CR_ADDR. Its data carries the captured clock code in bits 6:5 and zeros in all other bits. Changes to `osc_ext_i` and `clk_code_i` after start have no effect.
- R6: A write is accepted on a clock edge where both `wr_req_o` and `wr_ack_i` are high. Until then, the request, address and data are held steady.
- R7: After the control-register write is accepted, `wr_req_o` stays low for exactly CR_WAIT_CYC cycles before the connection-memory pass begins.
- R8: The connection-memory pass issues CM_DEPTH writes to CM_BASE+0 through CM_BASE+CM_DEPTH-1, in ascending order, each with data CM_FILL. Each next write is presented in the cycle after the previous one is accepted.
- R9: `ode_o`, `trst_no` and `done_o` rise in the cycle after the last connection-memory write is accepted. They stay high until a new `start_i` restarts the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a bring-up sequence |
| osc_ext_i | input | 1 | External oscillator in use |
| clk_code_i | input | 2 | Device input clock rate code |
| dev_rst_no | output | 1 | Device reset, active low |
| trst_no | output | 1 | Test-access reset, active low |
| ode_o | output | 1 | Device output enable |
| wr_req_o | output | 1 | Register write request |
| wr_addr_o | output | AW | Write address |
| wr_data_o | output | DW | Write data |
| wr_ack_i | input | 1 | Write acknowledge |
| done_o | output | 1 | Sequence complete |

## Verification
All outputs are decoded from registered state, so each response appears exactly one cycle after the edge that causes it:

- The reset pulse starts in the cycle after `start_i` is sampled.
- The first write request is due SETTLE_UNIT_CYC×k cycles after `dev_rst_no` rises.
- Each accepted write moves the address in the following cycle.
- Output enable and done rise one cycle after the final acknowledge.

A behavioural reference in the bench advances on each rising edge from the same inputs. Every output is compared against it on the falling edge, after all registers have settled. Separate interval counters measure the reset width, the settling gap and the post-control-register gap from the pins. They are checked against the R3, R4 and R7 formulas at the end of each sequence, across all clock codes, the oscillator option and several acknowledge latencies.

// File: rtl/pwrup_init_pkg.sv
package pwrup_init_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST,
    ST_SETTLE,
    ST_CR_WR,
    ST_CR_WAIT,
    ST_CM_WR,
    ST_DONE
  } seq_state_e;

  // input clock rate codes carried in the control-register field
  localparam logic [1:0] CK_4M  = 2'b00;
  localparam logic [1:0] CK_8M  = 2'b01;
  localparam logic [1:0] CK_16M = 2'b10;

  localparam int unsigned CKF_LSB = 5;

endpackage

// File: rtl/pwrup_settle_sel.sv
module pwrup_settle_sel #(
  parameter int unsigned UNIT_CYC = 25000,
  parameter int unsigned W        = 17
) (
  input  logic         osc_ext_i,
  input  logic [1:0]   clk_code_i,
  output logic [W-1:0] settle_cyc_o
);
  import pwrup_init_pkg::*;

  localparam logic [W-1:0] ONE_U  = W'(UNIT_CYC);
  localparam logic [W-1:0] TWO_U  = W'(2 * UNIT_CYC);
  localparam logic [W-1:0] FOUR_U = W'(4 * UNIT_CYC);

  always_comb begin
    if (osc_ext_i) begin
      settle_cyc_o = ONE_U;
    end else begin
      unique case (clk_code_i)
        CK_4M:   settle_cyc_o = FOUR_U;
        CK_8M:   settle_cyc_o = TWO_U;
        default: settle_cyc_o = ONE_U;
      endcase
    end
  end

endmodule

// File: rtl/pwrup_dly_timer.sv
module pwrup_dly_timer #(
  parameter int unsigned W = 17
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         expire_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = (cnt_q == '0);

endmodule

// File: rtl/pwrup_cm_sweep.sv
module pwrup_cm_sweep #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned IW    = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          step_i,
  output logic [IW-1:0] idx_o,
  output logic          last_o
);

  localparam logic [IW-1:0] LAST_IDX = IW'(DEPTH - 1);

  logic [IW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= '0;
    else if (clr_i)   idx_q <= '0;
    else if (step_i)  idx_q <= idx_q + 1'b1;
  end

  assign idx_o  = idx_q;
  assign last_o = (idx_q == LAST_IDX);

  assert_idx_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= LAST_IDX);

endmodule

// File: rtl/pwrup_init_seq.sv
module pwrup_init_seq #(
  parameter int unsigned AW              = 14,
  parameter int unsigned DW              = 16,
  parameter int unsigned RST_PULSE_CYC   = 64,
  parameter int unsigned SETTLE_UNIT_CYC = 25000,
  parameter int unsigned CR_WAIT_CYC     = 25000,
  parameter int unsigned CM_DEPTH        = 1024,
  parameter logic [AW-1:0] CR_ADDR       = 'h0000,
  parameter logic [AW-1:0] CM_BASE       = 'h2000,
  parameter logic [DW-1:0] CM_FILL       = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          osc_ext_i,
  input  logic [1:0]    clk_code_i,
  output logic          dev_rst_no,
  output logic          trst_no,
  output logic          ode_o,
  output logic          wr_req_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  input  logic          wr_ack_i,
  output logic          done_o
);
  import pwrup_init_pkg::*;

  localparam int unsigned SETTLE_MAX = 4 * SETTLE_UNIT_CYC;
  localparam int unsigned DLY_A      = (RST_PULSE_CYC > CR_WAIT_CYC) ? RST_PULSE_CYC : CR_WAIT_CYC;
  localparam int unsigned DLY_MAX    = (DLY_A > SETTLE_MAX) ? DLY_A : SETTLE_MAX;
  localparam int unsigned CNT_W      = $clog2(DLY_MAX + 1);
  localparam int unsigned IDX_W      = (CM_DEPTH > 1) ? $clog2(CM_DEPTH) : 1;
  localparam logic [AW-1:0] CM_LAST  = CM_BASE + AW'(CM_DEPTH - 1);

  seq_state_e         state_q, state_d;
  logic               cfg_ext_q;
  logic [1:0]         cfg_code_q;
  logic               tmr_load, tmr_expire;
  logic [CNT_W-1:0]   tmr_val;
  logic [CNT_W-1:0]   settle_cyc;
  logic               sw_clr, sw_step, sw_last;
  logic [IDX_W-1:0]   sw_idx;
  logic [DW-1:0]      cr_word;
  logic               launch;

  assign launch = start_i && (state_q == ST_IDLE || state_q == ST_DONE);

  pwrup_settle_sel #(.UNIT_CYC(SETTLE_UNIT_CYC), .W(CNT_W)) u_settle (
    .osc_ext_i   (cfg_ext_q),
    .clk_code_i  (cfg_code_q),
    .settle_cyc_o(settle_cyc)
  );

  pwrup_dly_timer #(.W(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .expire_o  (tmr_expire)
  );

  pwrup_cm_sweep #(.DEPTH(CM_DEPTH), .IW(IDX_W)) u_sweep (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (sw_clr),
    .step_i(sw_step),
    .idx_o (sw_idx),
    .last_o(sw_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cfg_ext_q  <= 1'b0;
      cfg_code_q <= CK_16M;
    end else begin
      state_q <= state_d;
      if (launch) begin
        cfg_ext_q  <= osc_ext_i;
        cfg_code_q <= clk_code_i;
      end
    end
  end

  // timed states load N-1 on entry, so each lasts exactly N cycles
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sw_clr   = 1'b0;
    sw_step  = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE: if (start_i) begin
        state_d  = ST_RST;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(RST_PULSE_CYC - 1);
        sw_clr   = 1'b1;
      end
      ST_RST: if (tmr_expire) begin
        state_d  = ST_SETTLE;
        tmr_load = 1'b1;
        tmr_val  = settle_cyc - 1'b1;
      end
      ST_SETTLE: if (tmr_expire) state_d = ST_CR_WR;
      ST_CR_WR: if (wr_ack_i) begin
        state_d  = ST_CR_WAIT;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(CR_WAIT_CYC - 1);
      end
      ST_CR_WAIT: if (tmr_expire) state_d = ST_CM_WR;
      ST_CM_WR: if (wr_ack_i) begin
        if (sw_last) state_d = ST_DONE;
        else         sw_step = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    cr_word = '0;
    cr_word[CKF_LSB +: 2] = cfg_code_q;
  end

  assign dev_rst_no = (state_q != ST_RST);
  assign ode_o      = (state_q == ST_DONE);
  assign trst_no    = (state_q == ST_DONE);
  assign done_o     = (state_q == ST_DONE);
  assign wr_req_o   = (state_q == ST_CR_WR) || (state_q == ST_CM_WR);
  assign wr_addr_o  = (state_q == ST_CR_WR) ? CR_ADDR : CM_BASE + AW'(sw_idx);
  assign wr_data_o  = (state_q == ST_CR_WR) ? cr_word : CM_FILL;

  // interval counters for the timing checks
  logic [CNT_W:0] chk_low_cnt, chk_hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_low_cnt <= '0;
      chk_hi_cnt  <= '0;
    end else begin
      chk_low_cnt <= dev_rst_no ? '0 : chk_low_cnt + 1'b1;
      if (!dev_rst_no)          chk_hi_cnt <= '0;
      else if (chk_hi_cnt != '1) chk_hi_cnt <= chk_hi_cnt + 1'b1;
    end
  end

  assert_rst_width_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dev_rst_no) |-> chk_low_cnt == (CNT_W+1)'(RST_PULSE_CYC));

  assert_settle_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(wr_req_o) && wr_addr_o == CR_ADDR) |-> chk_hi_cnt == {1'b0, settle_cyc});

  assert_req_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && !wr_ack_i) |=> (wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o)));

  assert_ode_after_cm_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ode_o) |-> $past(wr_req_o && wr_ack_i && wr_addr_o == CM_LAST));

  assert_done_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  assert_no_req_in_rst_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dev_rst_no |-> (!wr_req_o && !ode_o));

endmodule

// File: tb/pwrup_init_seq_tb.sv
module pwrup_init_seq_tb;

  localparam int RST_C  = 5;
  localparam int UNIT_C = 12;
  localparam int CRW_C  = 9;
  localparam int DEPTH  = 4;
  localparam logic [13:0] CRA  = 14'h0004;
  localparam logic [13:0] CMB  = 14'h1000;
  localparam logic [15:0] FILL = 16'hA5C3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, osc = 1'b0, ack = 1'b0;
  logic [1:0] code = 2'b10;
  logic dev_rst_n, trst_n, ode, req, done;
  logic [13:0] addr;
  logic [15:0] data;

  always #10 clk = ~clk;

  pwrup_init_seq #(
    .RST_PULSE_CYC(RST_C), .SETTLE_UNIT_CYC(UNIT_C), .CR_WAIT_CYC(CRW_C),
    .CM_DEPTH(DEPTH), .CR_ADDR(CRA), .CM_BASE(CMB), .CM_FILL(FILL)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .osc_ext_i(osc),
    .clk_code_i(code), .dev_rst_no(dev_rst_n), .trst_no(trst_n), .ode_o(ode),
    .wr_req_o(req), .wr_addr_o(addr), .wr_data_o(data), .wr_ack_i(ack),
    .done_o(done)
  );

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int settle_of(input logic e, input logic [1:0] c);
    if (e) return UNIT_C;
    case (c)
      2'b00:   return 4 * UNIT_C;
      2'b01:   return 2 * UNIT_C;
      default: return UNIT_C;
    endcase
  endfunction

  // behavioural reference: phase 0 idle, 1 reset, 2 settle, 3 ctrl write,
  // 4 ctrl wait, 5 memory pass, 6 done
  int ph = 0, rem = 0, idx = 0;
  logic m_ext = 1'b0;
  logic [1:0] m_code = 2'b10;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; rem = 0; idx = 0;
    end else begin
      case (ph)
        0, 6: if (start) begin ph = 1; rem = RST_C; m_ext = osc; m_code = code; idx = 0; end
        1: if (rem == 1) begin ph = 2; rem = settle_of(m_ext, m_code); end else rem--;
        2: if (rem == 1) ph = 3; else rem--;
        3: if (ack) begin ph = 4; rem = CRW_C; end
        4: if (rem == 1) ph = 5; else rem--;
        5: if (ack) begin if (idx == DEPTH - 1) ph = 6; else idx++; end
        default: ph = 0;
      endcase
    end
  end

  // interval monitors and acknowledge driver
  int ack_lat = 0, wait_ctr = 0, cm_acks = 0;
  int low_len = 0, meas_low = -1, since = 0, meas_settle = -1, run = 0, meas_gap = -1;
  bit armed = 0, saw_cr = 0, prev_rst = 1, prev_req = 0, stray = 0;

  always @(negedge clk) begin
    logic [15:0] e_data;
    logic [13:0] e_addr;
    e_addr = (ph == 3) ? CRA : CMB + 14'(idx);
    e_data = (ph == 3) ? (16'(m_code) << 5) : FILL;
    check(dev_rst_n == (ph != 1), "R3 dev_rst_no", dev_rst_n, ph != 1);
    check(ode == (ph == 6) && trst_n == (ph == 6), "R2 ode/trst", {ode, trst_n}, {2{ph == 6}});
    check(done == (ph == 6), "R9 done", done, ph == 6);
    check(req == (ph == 3 || ph == 5), "R6 wr_req", req, ph == 3 || ph == 5);
    if (ph == 3 || ph == 5) begin
      check(addr == e_addr, (ph == 3) ? "R5 addr" : "R8 addr", addr, e_addr);
      check(data == e_data, (ph == 3) ? "R5 data" : "R8 data", data, e_data);
    end
    if (!dev_rst_n) low_len++;
    else begin
      if (!prev_rst) begin meas_low = low_len; low_len = 0; armed = 1; since = 0; end
      if (armed) begin
        if (req) begin meas_settle = since; armed = 0; end else since++;
      end
    end
    if (req && addr == CRA) saw_cr = 1;
    if (!req) run++;
    else begin
      if (!prev_req && saw_cr && addr != CRA) begin meas_gap = run; saw_cr = 0; end
      run = 0;
    end
    prev_rst = dev_rst_n;
    prev_req = req;
    if (req) begin
      if (wait_ctr >= ack_lat) begin
        ack = 1'b1; wait_ctr = 0;
        if (addr != CRA) cm_acks++;
      end else begin
        ack = 1'b0; wait_ctr++;
      end
    end else begin
      ack = stray; wait_ctr = 0;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic run_seq(input logic e, input logic [1:0] c, input int lat, input bit poke);
    @(negedge clk);
    osc = e; code = c; ack_lat = lat; start = 1'b1;
    meas_low = -1; meas_settle = -1; meas_gap = -1; cm_acks = 0;
    @(negedge clk);
    start = 1'b0;
    osc = ~e; code = ~c;  // R5: later changes must not matter
    if (poke) begin
      repeat (RST_C + 3) @(negedge clk);
      start = 1'b1;  // R3: ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
    check(meas_low == RST_C, "R3 reset width", meas_low, RST_C);
    check(meas_settle == settle_of(e, c), "R4 settle gap", meas_settle, settle_of(e, c));
    check(meas_gap == CRW_C, "R7 ctrl wait gap", meas_gap, CRW_C);
    check(cm_acks == DEPTH, "R8 memory writes", cm_acks, DEPTH);
    repeat (6) @(negedge clk);
    check(done && ode && trst_n, "R9 done held", {done, ode, trst_n}, 3'b111);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(dev_rst_n && !trst_n && !ode && !req && !done, "R1 in reset",
          {dev_rst_n, trst_n, ode, req, done}, 5'b10000);
    rst_n = 1'b1;
    stray = 1'b1;  // R1: acknowledge with no request
    repeat (4) @(negedge clk);
    stray = 1'b0;
    check(dev_rst_n && !trst_n && !ode && !req && !done, "R1 idle",
          {dev_rst_n, trst_n, ode, req, done}, 5'b10000);
    run_seq(1'b0, 2'b00, 0, 1'b0);
    run_seq(1'b0, 2'b01, 2, 1'b1);
    run_seq(1'b0, 2'b10, 1, 1'b0);
    run_seq(1'b0, 2'b11, 3, 1'b0);
    run_seq(1'b1, 2'b00, 0, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule